// File: doc/BRIEF.md
# Accumulator Processor Datapath

This block holds the storage and arithmetic of a small accumulator machine. It has a data memory, a separate program memory, an accumulator `x`, an operand register `y`, an ALU with a one-bit condition flag, an instruction register and a program counter. It makes no decisions of its own. An external microsequencer drives one control line per action: memory read and write, register loads, the source select for `x`, the ALU operation, flag update, program read, instruction load, and the program counter load with its source select. The block returns the instruction register and the flag to that sequencer so that it can decode and branch.

Every register updates on the rising clock edge. Both memories are register arrays with combinational reads. The data memory is addressed by the low address field of the instruction register, and the program memory is addressed by the program counter. A dedicated initialisation port fills either memory before the program runs.

Top module: `acc_datapath`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, pc, x, y, the instruction register and the flag all read zero.
- R2: When x_ld is high, x_sel is 0 and mem_rd is high, x takes the data-memory word at the address held in ir[AW-1:0] at the next edge.
- R3: When y_ld is high, y takes the data-memory word at ir[AW-1:0]. The value of x_sel has no effect on y, which has no other source.
- R4: When x_ld is high and x_sel is 1, x takes the selected result modulo 2^DW. The codes are: 0 gives x+y, 1 gives x−y, 2 gives x+1, 3 gives x−1.
- R5: Code 4 loads x with the bitwise AND of x and y, and code 5 loads x with their bitwise OR, under the same x_ld and x_sel=1 conditions.
- R6: With flag_ld high, code 6 sets the flag to (x==y) and code 7 sets it to (x==0). Neither code changes x, even when x_ld is high with x_sel=1.
- R7: The flag keeps its value on every cycle that does not combine flag_ld high with code 6 or 7. This includes cycles where flag_ld is high with codes 0 to 5.
- R8: When mem_wr is high, the current x is written to data memory at ir[AW-1:0] on that edge, and a later read of that address returns it.
- R9: When ir_ld and pgm_rd are both high, the instruction register takes the program-memory word at the current pc.
- R10: When pc_ld is high, pc becomes pc+1 modulo 2^AW if pc_sel is 0, or ir[AW-1:0] if pc_sel is 1.
- R11: Any register whose load control is low keeps its value.
- R12: init_dwe writes init_ddata into data memory, and init_pwe writes init_pdata into program memory, at init_addr. When init_dwe and mem_wr are high together, init_dwe takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| init_dwe | input | 1 | Initialisation write strobe for data memory |
| init_pwe | input | 1 | Initialisation write strobe for program memory |
| init_addr | input | AW | Initialisation address |
| init_ddata | input | DW | Initialisation word for data memory |
| init_pdata | input | OPW+AW | Initialisation word for program memory |
| mem_rd | input | 1 | Enables the data-memory read value onto the x/y inputs |
| mem_wr | input | 1 | Stores x into data memory |
| x_ld | input | 1 | Load enable of x |
| y_ld | input | 1 | Load enable of y |
| x_sel | input | 1 | Source of x: 0 memory, 1 ALU |
| alu_op | input | 3 | ALU operation code (see R4 to R6) |
| flag_ld | input | 1 | Flag update enable for comparison codes |
| pgm_rd | input | 1 | Enables the program-memory read value |
| ir_ld | input | 1 | Load enable of the instruction register |
| pc_ld | input | 1 | Load enable of the program counter |
| pc_sel | input | 1 | Source of pc: 0 increment, 1 address field |
| ir_o | output | OPW+AW | Instruction register |
| flag_o | output | 1 | Condition flag |
| x_o | output | DW | Accumulator x |
| y_o | output | DW | Operand register y |
| pc_o | output | AW | Program counter |

## Verification
The bench builds the block with its defaults: DW=8, AW=5 and OPW=3. These give 32-entry memories. With that depth a jump to address 31 followed by one increment shows the counter wrap within a few cycles. An 8-bit word lets the subtract and decrement cases wrap below zero, and a subtract of equal operands produces zero for the zero-test comparison. A long run of random control words then mixes loads, stores, jumps and comparisons at every address against a reference model.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_INC = 3'd2,
        OP_DEC = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_EQ  = 3'd6,
        OP_EQZ = 3'd7
    } alu_op_e;

    function automatic logic is_cmp(input alu_op_e op);
        return (op == OP_EQ) || (op == OP_EQZ);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o,
    output logic          cmp_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] and_v;
    logic [DW-1:0] or_v;

    // bitwise logic built per bit
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign and_v[i] = a_i[i] & b_i[i];
        assign or_v[i]  = a_i[i] | b_i[i];
    end

    always_comb begin
        res_o = a_i;
        cmp_o = 1'b0;
        unique case (op_i)
            OP_ADD: res_o = a_i + b_i;
            OP_SUB: res_o = a_i - b_i;
            OP_INC: res_o = a_i + ONE;
            OP_DEC: res_o = a_i - ONE;
            OP_AND: res_o = and_v;
            OP_OR:  res_o = or_v;
            OP_EQ:  cmp_o = (a_i == b_i);
            OP_EQZ: cmp_o = (a_i == '0);
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];

endmodule

// File: rtl/acc_pc_next.sv
module acc_pc_next #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] target_i,
    input  logic          sel_i,
    output logic [AW-1:0] next_o
);

    logic [AW-1:0] step_v;

    assign step_v = pc_i + AW'(1);
    assign next_o = sel_i ? target_i : step_v;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 5,
    parameter int OPW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_dwe,
    input  logic                init_pwe,
    input  logic [AW-1:0]       init_addr,
    input  logic [DW-1:0]       init_ddata,
    input  logic [OPW+AW-1:0]   init_pdata,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic                x_ld,
    input  logic                y_ld,
    input  logic                x_sel,
    input  logic [2:0]          alu_op,
    input  logic                flag_ld,
    input  logic                pgm_rd,
    input  logic                ir_ld,
    input  logic                pc_ld,
    input  logic                pc_sel,
    output logic [OPW+AW-1:0]   ir_o,
    output logic                flag_o,
    output logic [DW-1:0]       x_o,
    output logic [DW-1:0]       y_o,
    output logic [AW-1:0]       pc_o
);

    localparam int IW    = OPW + AW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [IW-1:0] ir;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic          flag;
    } state_t;

    state_t st_d, st_q;

    alu_op_e       op_v;
    logic [AW-1:0] ads_v;
    logic [DW-1:0] dmem_rdata;
    logic [IW-1:0] pmem_rdata;
    logic [DW-1:0] dmem_val;
    logic [IW-1:0] pmem_val;
    logic [DW-1:0] alu_res;
    logic          alu_cmp;
    logic [AW-1:0] pc_next;
    logic          dmem_we;
    logic [AW-1:0] dmem_waddr;
    logic [DW-1:0] dmem_wdata;

    assign op_v  = alu_op_e'(alu_op);
    assign ads_v = st_q.ir[AW-1:0];

    // data memory write port: initialisation wins over a store
    assign dmem_we    = init_dwe | mem_wr;
    assign dmem_waddr = init_dwe ? init_addr  : ads_v;
    assign dmem_wdata = init_dwe ? init_ddata : st_q.x;

    acc_mem #(.WIDTH(DW), .DEPTH(DEPTH)) u_dmem (
        .clk     (clk),
        .we_i    (dmem_we),
        .waddr_i (dmem_waddr),
        .wdata_i (dmem_wdata),
        .raddr_i (ads_v),
        .rdata_o (dmem_rdata)
    );

    acc_mem #(.WIDTH(IW), .DEPTH(DEPTH)) u_pmem (
        .clk     (clk),
        .we_i    (init_pwe),
        .waddr_i (init_addr),
        .wdata_i (init_pdata),
        .raddr_i (st_q.pc),
        .rdata_o (pmem_rdata)
    );

    acc_alu #(.DW(DW)) u_alu (
        .a_i   (st_q.x),
        .b_i   (st_q.y),
        .op_i  (op_v),
        .res_o (alu_res),
        .cmp_o (alu_cmp)
    );

    acc_pc_next #(.AW(AW)) u_pcn (
        .pc_i     (st_q.pc),
        .target_i (ads_v),
        .sel_i    (pc_sel),
        .next_o   (pc_next)
    );

    assign dmem_val = mem_rd ? dmem_rdata : '0;
    assign pmem_val = pgm_rd ? pmem_rdata : '0;

    always_comb begin
        st_d = st_q;
        if (x_ld) begin
            if (!x_sel) begin
                st_d.x = dmem_val;
            end else if (!is_cmp(op_v)) begin
                st_d.x = alu_res;
            end
        end
        if (y_ld) begin
            st_d.y = dmem_val;
        end
        if (flag_ld && is_cmp(op_v)) begin
            st_d.flag = alu_cmp;
        end
        if (ir_ld) begin
            st_d.ir = pmem_val;
        end
        if (pc_ld) begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_o   = st_q.ir;
    assign flag_o = st_q.flag;
    assign x_o    = st_q.x;
    assign y_o    = st_q.y;
    assign pc_o   = st_q.pc;

    // R2
    x_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_ld && !x_sel && mem_rd) |=> (x_o == $past(dmem_rdata)));

    // R6
    cmp_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_ld && x_sel && (alu_op >= 3'd6)) |=> $stable(x_o));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_ld && (alu_op >= 3'd6)) |=> $stable(flag_o));

    // R9
    ir_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_ld && pgm_rd) |=> (ir_o == $past(pmem_rdata)));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && !pc_sel) |=> (pc_o == AW'($past(pc_o) + AW'(1))));

    // R10
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && pc_sel) |=> (pc_o == $past(ir_o[AW-1:0])));

    // R11
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_ld |=> $stable(y_o));

endmodule

// File: tb/sim_acc_datapath.sv
module sim_acc_datapath;

    localparam int DW  = 8;
    localparam int AW  = 5;
    localparam int OPW = 3;
    localparam int IW  = OPW + AW;
    localparam int N   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_dwe = 0, init_pwe = 0;
    logic [AW-1:0] init_addr = '0;
    logic [DW-1:0] init_ddata = '0;
    logic [IW-1:0] init_pdata = '0;
    logic mem_rd = 0, mem_wr = 0, x_ld = 0, y_ld = 0, x_sel = 0;
    logic [2:0] alu_op = '0;
    logic flag_ld = 0, pgm_rd = 0, ir_ld = 0, pc_ld = 0, pc_sel = 0;
    logic [IW-1:0] ir_o;
    logic          flag_o;
    logic [DW-1:0] x_o, y_o;
    logic [AW-1:0] pc_o;

    always #10 clk = ~clk;

    acc_datapath #(.DW(DW), .AW(AW), .OPW(OPW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .init_dwe(init_dwe), .init_pwe(init_pwe), .init_addr(init_addr),
        .init_ddata(init_ddata), .init_pdata(init_pdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .x_ld(x_ld), .y_ld(y_ld),
        .x_sel(x_sel), .alu_op(alu_op), .flag_ld(flag_ld), .pgm_rd(pgm_rd),
        .ir_ld(ir_ld), .pc_ld(pc_ld), .pc_sel(pc_sel),
        .ir_o(ir_o), .flag_o(flag_o), .x_o(x_o), .y_o(y_o), .pc_o(pc_o)
    );

    // reference model
    logic [DW-1:0] m_dmem [N];
    logic [IW-1:0] m_pmem [N];
    logic [DW-1:0] m_x = '0, m_y = '0;
    logic [IW-1:0] m_ir = '0;
    logic [AW-1:0] m_pc = '0;
    logic          m_flag = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    task automatic push(input int sel, input logic [7:0] val, input string req);
        exp_t e;
        e.sel = sel; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_all(input string req);
        push(0, m_x, req);
        push(1, m_y, req);
        push(2, 8'(m_pc), req);
        push(3, m_ir, req);
        push(4, 8'(m_flag), req);
    endtask

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                string nm;
                e = exp_q.pop_front();
                case (e.sel)
                    0: begin act = x_o;        nm = "x";    end
                    1: begin act = y_o;        nm = "y";    end
                    2: begin act = 8'(pc_o);   nm = "pc";   end
                    3: begin act = ir_o;       nm = "ir";   end
                    default: begin act = 8'(flag_o); nm = "flag"; end
                endcase
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s %s actual=%0h expected=%0h", e.req, nm, act, e.val);
                end
            end
        end
    end

    task automatic init_write(input bit prog, input int a, input logic [7:0] v);
        @(negedge clk);
        init_addr = AW'(a);
        if (prog) begin init_pwe = 1; init_pdata = v; m_pmem[a] = v; end
        else      begin init_dwe = 1; init_ddata = v; m_dmem[a] = v; end
        @(posedge clk); #1;
        init_pwe = 0; init_dwe = 0;
    endtask

    task automatic step(input string req, input logic mrd, input logic mwr,
                        input logic xl, input logic yl, input logic xs,
                        input logic [2:0] op, input logic fl, input logic prd,
                        input logic irl, input logic pcl, input logic pcs);
        logic [AW-1:0] ads;
        logic [DW-1:0] mval, res, nx, ny;
        logic [IW-1:0] nir;
        logic [AW-1:0] npc;
        logic          cmp, nflag;
        @(negedge clk);
        mem_rd = mrd; mem_wr = mwr; x_ld = xl; y_ld = yl; x_sel = xs;
        alu_op = op; flag_ld = fl; pgm_rd = prd; ir_ld = irl;
        pc_ld = pcl; pc_sel = pcs;
        ads  = m_ir[AW-1:0];
        mval = mrd ? m_dmem[ads] : '0;
        cmp  = 1'b0;
        res  = m_x;
        case (op)
            3'd0: res = m_x + m_y;
            3'd1: res = m_x - m_y;
            3'd2: res = m_x + 8'd1;
            3'd3: res = m_x - 8'd1;
            3'd4: res = m_x & m_y;
            3'd5: res = m_x | m_y;
            3'd6: cmp = (m_x == m_y);
            default: cmp = (m_x == 8'd0);
        endcase
        nx    = xl ? (xs ? res : mval) : m_x;
        ny    = yl ? mval : m_y;
        nflag = (fl && op >= 3'd6) ? cmp : m_flag;
        nir   = irl ? (prd ? m_pmem[m_pc] : '0) : m_ir;
        npc   = pcl ? (pcs ? ads : m_pc + AW'(1)) : m_pc;
        @(posedge clk); #1;
        if (mwr) m_dmem[ads] = m_x;
        m_x = nx; m_y = ny; m_flag = nflag; m_ir = nir; m_pc = npc;
        push_all(req);
    endtask

    task automatic fetch(input string req);
        step(req, 0, 0, 0, 0, 0, 3'd0, 0, 1, 1, 0, 0);   // R9
        step("R10", 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 1, 0);
    endtask

    task automatic alu(input string req, input logic [2:0] op);
        step(req, 0, 0, 1, 0, 1, op, (op >= 3'd6), 0, 0, 0, 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12: fill both memories through the initialisation port
        for (int i = 0; i < N; i++) begin
            init_write(1, i, 8'((i << AW) | ((i * 7 + 3) % N)));
            init_write(0, i, 8'(i * 13 + 5));
        end
        init_write(1, 2, 8'h5F);   // address field 31
        @(negedge clk);
        rst_n = 1;
        push_all("R1");
        @(negedge clk);

        fetch("R9");                                              // ir ads 3
        step("R12", 1, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, 0);          // ldx
        step("R2",  1, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, 0);
        fetch("R9");                                              // ads 10
        step("R3",  1, 0, 0, 1, 0, 3'd0, 0, 0, 0, 0, 0);          // ldy
        alu("R4", 3'd0);
        alu("R4", 3'd1);
        alu("R4", 3'd2);
        alu("R4", 3'd3);
        alu("R5", 3'd4);
        alu("R5", 3'd5);
        alu("R6", 3'd6);
        alu("R6", 3'd7);
        step("R7", 0, 0, 1, 0, 1, 3'd0, 1, 0, 0, 0, 0);           // flag_ld with add
        step("R11", 0, 0, 0, 0, 0, 3'd1, 0, 0, 0, 0, 0);          // idle
        step("R3",  1, 0, 0, 1, 1, 3'd0, 0, 0, 0, 0, 0);          // y ignores x_sel
        alu("R4", 3'd3);
        step("R8",  0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0);          // stx
        alu("R8", 3'd2);
        step("R8",  1, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, 0);          // reload
        step("R12", 1, 1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0);          // store during...
        fetch("R9");                                              // pmem[2], ads 31
        step("R10", 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 1, 1);          // jump to 31
        fetch("R10");                                             // wrap to 0
        step("R6",  1, 0, 1, 1, 0, 3'd0, 0, 0, 0, 0, 0);          // x=y
        alu("R6", 3'd6);
        alu("R4", 3'd1);                                          // x-x = 0
        alu("R6", 3'd7);

        for (int k = 0; k < 400; k++) begin
            logic [15:0] r;
            r = 16'($urandom);
            step("R11", r[0], r[1], r[2], r[3], r[4], r[7:5], r[8],
                 r[9], r[10], r[11], r[12]);
        end
        step("R11", 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule